// File: doc/BRIEF.md
# Sector Erase Batch Window Timer

This block sits behind a flash command decoder. It gathers sector erase requests into one batch before the erase engine starts. The first accepted sector erase command opens an acceptance window. Each later sector erase command that arrives while the window is open adds its sector to a selection mask and restarts the window from zero. The batch erase starts only when a full window passes with no new sector command. The block then raises a one-cycle start pulse and sets the status bit, which software reads as DQ3.

While the erase is running, the block refuses every command except erase suspend. A chip erase command issued while the block is idle skips the window: it selects every sector and starts the erase at once. A completion pulse from the erase engine clears the mask and returns the block to idle. The erase algorithm itself lives outside this block.

The window length is set in clock cycles by a parameter. For a 50 µs window at 125 MHz this is 6250 cycles.

Top module: `erase_batch_timer`

## Requirements
- R1: After reset, `dq3_status`, `sector_mask`, `erase_start` and `cmd_accept` are all 0.
- R2: In idle, a valid command with `cmd_kind` = 1 (sector erase) and `cmd_sector` < NUM_SECT does three things one cycle later: it sets mask bit `cmd_sector`, it pulses `cmd_accept` for one cycle, and it leaves `dq3_status` at 0.
- R3: While the window is open, each further valid sector erase command has the same effects. It also restarts the full timeout, and a restart never clears bits already set.
- R4: When WIN_CYCLES clock edges have passed after the edge that captured the last accepted sector command, `dq3_status` goes from 0 to 1 and `erase_start` pulses for exactly one cycle. Both change on the same edge.
- R5: In idle, a valid command with `cmd_kind` = 2 (chip erase) sets every mask bit, raises `dq3_status` and pulses `erase_start` and `cmd_accept`, all one cycle later and with no window.
- R6: While `dq3_status` is 1, sector erase, chip erase and other commands (`cmd_kind` = 0) are ignored: there is no accept pulse and the mask does not change.
- R7: While `dq3_status` is 1, a valid command with `cmd_kind` = 3 (erase suspend) pulses `cmd_accept` one cycle later, and `dq3_status` stays 1.
- R8: An `erase_done` pulse while `dq3_status` is 1 clears `dq3_status` and the mask one cycle later. An `erase_done` pulse at any other time is ignored.
- R9: A sector erase command with `cmd_sector` >= NUM_SECT is ignored. It gives no accept pulse, sets no mask bit and opens no window.
- R10: While the window is open, chip erase, suspend and other commands are ignored. They do not restart or stop the timeout and they give no accept pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_kind | input | 2 | 0 other, 1 sector erase, 2 chip erase, 3 erase suspend |
| cmd_sector | input | SECT_W | Sector index for a sector erase command |
| erase_done | input | 1 | Erase engine finished the batch |
| dq3_status | output | 1 | 0 while idle or collecting sectors, 1 once the erase has begun |
| sector_mask | output | NUM_SECT | Sectors selected for the current batch |
| erase_start | output | 1 | One-cycle pulse when the erase begins |
| cmd_accept | output | 1 | One-cycle pulse for each accepted command |

## Verification
The in-line assertions check on every cycle that the start pulse lasts one cycle and comes with the status bit set. They also check that the mask holds still while an erase runs, that the mask is empty when the status bit falls, that the timeout count stays within range and returns to zero on every restart, and that an accept pulse always comes with a non-empty mask. Some behaviour only the bench scenarios can show: the exact cycle on which the window expires after a restart, the fact that foreign commands inside the window neither extend nor cut the timeout, the rejection of out-of-range sector indices, and the immediate start of a chip erase.

// File: rtl/ebt_pkg.sv
`timescale 1ns/1ps
package ebt_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER   = 2'd0,
    CMD_SECTOR  = 2'd1,
    CMD_CHIP    = 2'd2,
    CMD_SUSPEND = 2'd3
  } ebt_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } ebt_state_e;
endpackage

// File: rtl/ebt_win_timer.sv
`timescale 1ns/1ps
module ebt_win_timer #(
  parameter int WIN_CYCLES = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  // Count enable and next value
  always_comb begin
    count_en = restart | run;
    count_d  = count_q;
    if (restart)
      count_d = '0;
    else if (run && count_q != LAST)
      count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (count_en)
      count_q <= count_d;
  end

  assign expired = run && (count_q == LAST) && !restart;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LAST); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0)); // R3
endmodule

// File: rtl/ebt_sect_mask.sv
`timescale 1ns/1ps
module ebt_sect_mask #(
  parameter int NUM_SECT = 6,
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [SECT_W-1:0]   set_idx,
  input  logic                set_all,
  input  logic                clr,
  output logic [NUM_SECT-1:0] mask
);
  logic [NUM_SECT-1:0] mask_q, mask_d;
  logic                mask_en;

  assign mask_en = set_en | set_all | clr;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    always_comb begin
      if (clr)
        mask_d[i] = 1'b0;
      else if (set_all)
        mask_d[i] = 1'b1;
      else if (set_en && set_idx == SECT_W'(i))
        mask_d[i] = 1'b1;
      else
        mask_d[i] = mask_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (mask_en)
      mask_q <= mask_d;
  end

  assign mask = mask_q;

  AST_MASK_ADD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !set_all && !clr) |=>
      ($countones(mask_q) <= $countones($past(mask_q)) + 1) &&
      (($past(mask_q) & ~mask_q) == '0)); // R3
endmodule

// File: rtl/ebt_ctrl.sv
`timescale 1ns/1ps
module ebt_ctrl
  import ebt_pkg::*;
#(
  parameter int NUM_SECT = 6,
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              erase_done,
  input  logic              expired,
  output logic              restart,
  output logic              run,
  output logic              set_en,
  output logic              set_all,
  output logic              clr,
  output logic              busy,
  output logic              start_pulse,
  output logic              accept_pulse
);
  ebt_state_e state_q, state_d;
  logic       start_q, start_d;
  logic       acc_q, acc_d;
  logic       is_sect, is_chip, is_susp;

  assign is_sect = cmd_valid && (ebt_cmd_e'(cmd_kind) == CMD_SECTOR) &&
                   ({1'b0, cmd_sector} < (SECT_W+1)'(NUM_SECT));
  assign is_chip = cmd_valid && (ebt_cmd_e'(cmd_kind) == CMD_CHIP);
  assign is_susp = cmd_valid && (ebt_cmd_e'(cmd_kind) == CMD_SUSPEND);

  // Next-state process
  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    set_en  = 1'b0;
    set_all = 1'b0;
    clr     = 1'b0;
    start_d = 1'b0;
    acc_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (is_sect) begin
          state_d = ST_WINDOW;
          restart = 1'b1;
          set_en  = 1'b1;
          acc_d   = 1'b1;
        end else if (is_chip) begin
          state_d = ST_ERASE;
          set_all = 1'b1;
          start_d = 1'b1;
          acc_d   = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (is_sect) begin
          restart = 1'b1;
          set_en  = 1'b1;
          acc_d   = 1'b1;
        end else if (expired) begin
          state_d = ST_ERASE;
          start_d = 1'b1;
        end
      end
      ST_ERASE: begin
        if (erase_done) begin
          state_d = ST_IDLE;
          clr     = 1'b1;
        end else if (is_susp) begin
          acc_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      acc_q   <= acc_d;
    end
  end

  assign run          = (state_q == ST_WINDOW);
  assign busy         = (state_q == ST_ERASE);
  assign start_pulse  = start_q;
  assign accept_pulse = acc_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (state_q == ST_ERASE)); // R4
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R4
  AST_ERASE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && $past(state_q) != ST_ERASE) |-> start_q); // R4
endmodule

// File: rtl/erase_batch_timer.sv
`timescale 1ns/1ps
module erase_batch_timer #(
  parameter int NUM_SECT   = 6,
  parameter int WIN_CYCLES = 6250,
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_kind,
  input  logic [SECT_W-1:0]   cmd_sector,
  input  logic                erase_done,
  output logic                dq3_status,
  output logic [NUM_SECT-1:0] sector_mask,
  output logic                erase_start,
  output logic                cmd_accept
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic restart, run, expired;
  logic set_en, set_all, clr;

  ebt_ctrl #(.NUM_SECT(NUM_SECT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd_valid    (cmd_valid),
    .cmd_kind     (cmd_kind),
    .cmd_sector   (cmd_sector),
    .erase_done   (erase_done),
    .expired      (expired),
    .restart      (restart),
    .run          (run),
    .set_en       (set_en),
    .set_all      (set_all),
    .clr          (clr),
    .busy         (dq3_status),
    .start_pulse  (erase_start),
    .accept_pulse (cmd_accept)
  );

  ebt_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (restart),
    .run     (run),
    .expired (expired)
  );

  ebt_sect_mask #(.NUM_SECT(NUM_SECT)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (set_en),
    .set_idx (cmd_sector),
    .set_all (set_all),
    .clr     (clr),
    .mask    (sector_mask)
  );

  AST_BUSY_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dq3_status && !erase_start) |-> $stable(sector_mask)); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(dq3_status) |-> (sector_mask == '0)); // R8
  AST_ACCEPT_MASK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_accept |-> (sector_mask != '0)); // R2
  AST_DQ3_AT_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(dq3_status) |-> erase_start); // R4
endmodule

// File: tb/erase_batch_timer_tb_top.sv
`timescale 1ns/1ps
module erase_batch_timer_tb_top;
  import ebt_pkg::*;

  localparam int NS  = 6;
  localparam int WIN = 8;
  localparam int SW  = 3;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_kind;
  logic [SW-1:0] cmd_sector;
  logic          erase_done;
  logic          dq3_status;
  logic [NS-1:0] sector_mask;
  logic          erase_start;
  logic          cmd_accept;

  erase_batch_timer #(.NUM_SECT(NS), .WIN_CYCLES(WIN)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_sector  (cmd_sector),
    .erase_done  (erase_done),
    .dq3_status  (dq3_status),
    .sector_mask (sector_mask),
    .erase_start (erase_start),
    .cmd_accept  (cmd_accept)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int            cyc;
    string         req;
    logic          dq3;
    logic [NS-1:0] mask;
    logic          st;
    logic          acc;
  } item_t;

  item_t sbq[$];
  int    cyc    = 0;
  int    n_chk  = 0;
  int    n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue the outputs expected k negedges from now
  task automatic expect_at(int k, string req, logic d, logic [NS-1:0] m,
                           logic s, logic a);
    item_t it;
    it.cyc  = cyc + k;
    it.req  = req;
    it.dq3  = d;
    it.mask = m;
    it.st   = s;
    it.acc  = a;
    sbq.push_back(it);
  endtask

  task automatic send(ebt_cmd_e kind, logic [SW-1:0] idx);
    cmd_valid  = 1'b1;
    cmd_kind   = kind;
    cmd_sector = idx;
    @(negedge clk);
    cmd_valid  = 1'b0;
    cmd_kind   = CMD_OTHER;
    cmd_sector = '0;
  endtask

  task automatic pulse_done();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  // Monitor side: pop due items and compare
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      n_chk++;
      if (dq3_status !== it.dq3 || sector_mask !== it.mask ||
          erase_start !== it.st || cmd_accept !== it.acc) begin
        n_fail++;
        $display("FAIL %s: actual dq3=%b mask=%b start=%b acc=%b, expected dq3=%b mask=%b start=%b acc=%b",
                 it.req, dq3_status, sector_mask, erase_start, cmd_accept,
                 it.dq3, it.mask, it.st, it.acc);
      end
    end
  end

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual run still active, expected completion");
    report_end();
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_kind   = CMD_OTHER;
    cmd_sector = '0;
    erase_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: quiet after reset
    expect_at(1, "R1", 1'b0, 6'b000000, 1'b0, 1'b0);
    @(negedge clk);

    // R2: first sector opens the window
    expect_at(1, "R2", 1'b0, 6'b000010, 1'b0, 1'b1);
    send(CMD_SECTOR, 3'd1);
    expect_at(1, "R2", 1'b0, 6'b000010, 1'b0, 1'b0);
    repeat (2) @(negedge clk);

    // R3: second sector adds a bit and restarts the timeout
    expect_at(1, "R3", 1'b0, 6'b100010, 1'b0, 1'b1);
    send(CMD_SECTOR, 3'd5);

    // R10: foreign commands inside the window are ignored
    expect_at(1, "R10", 1'b0, 6'b100010, 1'b0, 1'b0);
    send(CMD_CHIP, 3'd0);
    expect_at(1, "R10", 1'b0, 6'b100010, 1'b0, 1'b0);
    send(CMD_SUSPEND, 3'd0);
    expect_at(1, "R10", 1'b0, 6'b100010, 1'b0, 1'b0);
    send(CMD_OTHER, 3'd0);

    // R4: expiry exactly WIN edges after the last accepted sector
    expect_at(WIN - 1 - 3, "R4", 1'b0, 6'b100010, 1'b0, 1'b0);
    expect_at(WIN - 3,     "R4", 1'b1, 6'b100010, 1'b1, 1'b0);
    expect_at(WIN - 2,     "R4", 1'b1, 6'b100010, 1'b0, 1'b0);
    repeat (WIN - 2) @(negedge clk);

    // R6: commands ignored while erasing
    expect_at(1, "R6", 1'b1, 6'b100010, 1'b0, 1'b0);
    send(CMD_SECTOR, 3'd2);
    expect_at(1, "R6", 1'b1, 6'b100010, 1'b0, 1'b0);
    send(CMD_CHIP, 3'd0);
    expect_at(1, "R6", 1'b1, 6'b100010, 1'b0, 1'b0);
    send(CMD_OTHER, 3'd0);

    // R7: suspend accepted while erasing
    expect_at(1, "R7", 1'b1, 6'b100010, 1'b0, 1'b1);
    send(CMD_SUSPEND, 3'd0);

    // R8: completion clears; a stray completion is ignored
    expect_at(1, "R8", 1'b0, 6'b000000, 1'b0, 1'b0);
    pulse_done();
    expect_at(1, "R8", 1'b0, 6'b000000, 1'b0, 1'b0);
    pulse_done();

    // R9: out-of-range sector ignored, no window opens
    expect_at(1, "R9", 1'b0, 6'b000000, 1'b0, 1'b0);
    send(CMD_SECTOR, 3'd7);
    expect_at(WIN + 1, "R9", 1'b0, 6'b000000, 1'b0, 1'b0);
    repeat (WIN + 1) @(negedge clk);

    // R5: chip erase starts at once with every sector selected
    expect_at(1, "R5", 1'b1, 6'b111111, 1'b1, 1'b1);
    send(CMD_CHIP, 3'd0);
    expect_at(1, "R5", 1'b1, 6'b111111, 1'b0, 1'b0);
    @(negedge clk);
    expect_at(1, "R8", 1'b0, 6'b000000, 1'b0, 1'b0);
    pulse_done();

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d items left, expected 0", sbq.size());
    end
    report_end();
    $finish;
  end
endmodule